// File: doc/BRIEF.md
# Backplane Bus Requester with Locked-Sequence Hold

This block requests a shared backplane bus on behalf of a local processor. The bus has a single busy line. The block raises a request, waits for the arbiter's grant and then drives the busy line to claim the bus. It then decides when to let the bus go. Two release policies can be selected. In one, ownership ends as soon as no local transfer is pending. In the other, ownership is kept until some other master asks for the bus.

A processor running an indivisible sequence raises a lock input. A multi-operand compare-and-swap touches several addresses, so the address strobe toggles between its transfers, and a strobe on its own cannot keep such a sequence atomic. For as long as the lock input is high, the block keeps the busy line asserted across every transfer and every gap between them. A request from another master that arrives during the lock is held off until the lock ends. The lockActive output tells downstream logic, such as a dual-port memory arbiter, whether a real locked sequence is in progress. This lets that logic tell a lock apart from an idle hold under the release-on-request policy, so it never locks up on a stale hold.

Top module: `bus_requester`

## Requirements
- R1: After reset, and whenever rstN is low, brOut, busyOut and lockActive are all 0.
- R2: While the bus is neither requested nor owned, a clock edge that samples cpuReq=1 or cpuLock=1 sets brOut to 1 after that edge, and busyOut stays 0.
- R3: While brOut=1, a clock edge that samples bgIn=1 sets busyOut to 1 and clears brOut after that same edge.
- R4: While busyOut=1, a clock edge that samples cpuLock=1 leaves busyOut at 1, whatever cpuReq, otherReq and rorMode are doing.
- R5: With rorMode=0 (release when done), an owned bus is released after the first edge that samples cpuReq=0 and cpuLock=0: busyOut goes to 0.
- R6: With rorMode=1 (release on request), an owned bus stays owned while otherReq=0, even with no local activity. It is released after an edge that samples otherReq=1, cpuReq=0 and cpuLock=0.
- R7: An otherReq=1 seen while cpuLock=1 does not release the bus. Release follows the first edge at which cpuLock is 0 and cpuReq is 0.
- R8: While busyOut=1, brOut stays 0. A local transfer that arrives during ownership reuses the bus and is not arbitrated again.
- R9: lockActive is 1 exactly when cpuLock is 1 and busyOut is 1. It follows cpuLock without waiting for a clock edge.
- R10: A bgIn=1 that arrives while no request is outstanding is ignored: busyOut stays 0.
- R11: Under rorMode=1, ownership never counts as locked after cpuLock falls. If otherReq is already 1, the bus is released after the edge that samples cpuLock=0. If otherReq is 0, the hold continues with lockActive=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Local processor has a bus transfer pending |
| cpuLock | input | 1 | Processor indivisible-sequence flag |
| bgIn | input | 1 | Bus grant from the arbiter |
| otherReq | input | 1 | Bus request seen from another master |
| rorMode | input | 1 | 1 = release on request, 0 = release when done |
| brOut | output | 1 | Bus request to the arbiter |
| busyOut | output | 1 | Busy line drive (bus owned) |
| lockActive | output | 1 | Owned bus is inside a locked sequence |

## Verification
The hardest situation to reach is a locked multi-operand sequence in which the local strobe falls between operands while another master is already requesting the bus. At that moment every release condition except the lock holds. The stimulus table builds this directly: it grants the bus under lock, drops cpuReq between operands, and raises otherReq early. It does this under both release policies, and in release-on-request mode it also ends a lock with otherReq both high and low, which shows that no hold is stretched past the lock and that lockActive falls at once.

// File: rtl/busreq_pkg.sv
package busreq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2
  } reqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic raiseReq;
    logic dropReq;
    logic takeBusy;
    logic dropBusy;
  } ctrlStrobe_t;

endpackage

// File: rtl/busreq_ctrl.sv
module busreq_ctrl
  import busreq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuLock,
  input  logic        bgIn,
  input  logic        otherReq,
  input  logic        rorMode,
  output ctrlStrobe_t strobe
);

  reqState_t state;
  reqState_t stateNext;
  logic      keepBus;
  logic      wantBus;

  // a lock always keeps the bus; local work keeps it; ROR keeps it until asked
  assign wantBus = cpuReq | cpuLock;
  assign keepBus = wantBus | (rorMode & ~otherReq);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (wantBus) begin
          stateNext       = ST_REQ;
          strobe.raiseReq = 1'b1;
        end
      end
      ST_REQ: begin
        if (bgIn) begin
          stateNext       = ST_OWN;
          strobe.dropReq  = 1'b1;
          strobe.takeBusy = 1'b1;
        end
      end
      ST_OWN: begin
        if (!keepBus) begin
          stateNext       = ST_IDLE;
          strobe.dropBusy = 1'b1;
        end
      end
      default: begin
        stateNext       = ST_IDLE;
        strobe.dropReq  = 1'b1;
        strobe.dropBusy = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/busreq_dp.sv
module busreq_dp
  import busreq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        cpuLock,
  output logic        brOut,
  output logic        busyOut,
  output logic        lockActive
);

  logic brReg;
  logic busyReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      brReg   <= 1'b0;
      busyReg <= 1'b0;
    end else begin
      if (strobe.raiseReq)     brReg <= 1'b1;
      else if (strobe.dropReq) brReg <= 1'b0;
      if (strobe.takeBusy)      busyReg <= 1'b1;
      else if (strobe.dropBusy) busyReg <= 1'b0;
    end
  end

  assign brOut      = brReg;
  assign busyOut    = busyReg;
  assign lockActive = busyReg & cpuLock;

endmodule

// File: rtl/bus_requester.sv
module bus_requester
  import busreq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cpuReq,
  input  logic cpuLock,
  input  logic bgIn,
  input  logic otherReq,
  input  logic rorMode,
  output logic brOut,
  output logic busyOut,
  output logic lockActive
);

  ctrlStrobe_t strobe;

  busreq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuLock  (cpuLock),
    .bgIn     (bgIn),
    .otherReq (otherReq),
    .rorMode  (rorMode),
    .strobe   (strobe)
  );

  busreq_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuLock    (cpuLock),
    .brOut      (brOut),
    .busyOut    (busyOut),
    .lockActive (lockActive)
  );

endmodule

// File: rtl/bus_requester_chk.sv
module bus_requester_chk (
  input logic clk,
  input logic rstN,
  input logic cpuReq,
  input logic cpuLock,
  input logic bgIn,
  input logic otherReq,
  input logic rorMode,
  input logic brOut,
  input logic busyOut,
  input logic lockActive
);

  AST_REQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (!brOut && !busyOut && (cpuReq || cpuLock)) |=> (brOut && !busyOut)); // R2

  AST_GRANT_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (brOut && bgIn) |=> (busyOut && !brOut)); // R3

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && cpuLock) |=> busyOut); // R4

  AST_RWD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !rorMode && !cpuReq && !cpuLock) |=> !busyOut); // R5

  AST_ROR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && rorMode && !otherReq) |=> busyOut); // R6

  AST_NO_REQ_WHILE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    busyOut |-> !brOut); // R8

  AST_LOCK_FLAG_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |-> (busyOut && cpuLock)); // R9

  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (!brOut && !busyOut && bgIn) |=> !busyOut); // R10

endmodule

bind bus_requester bus_requester_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cpuReq     (cpuReq),
  .cpuLock    (cpuLock),
  .bgIn       (bgIn),
  .otherReq   (otherReq),
  .rorMode    (rorMode),
  .brOut      (brOut),
  .busyOut    (busyOut),
  .lockActive (lockActive)
);

// File: tb/bus_requester_bench.sv
`timescale 1ns/1ps
module bus_requester_bench;

  logic clk = 1'b0;
  logic rstN;
  logic cpuReq, cpuLock, bgIn, otherReq, rorMode;
  logic brOut, busyOut, lockActive;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_requester u_bus_requester (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuLock(cpuLock), .bgIn(bgIn),
    .otherReq(otherReq), .rorMode(rorMode), .brOut(brOut), .busyOut(busyOut),
    .lockActive(lockActive)
  );

  // inputs {req,lock,grant,other,ror} then expected {br,busy,lockActive}
  localparam int NVEC = 28;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b00000_000, // 0  idle                       R1
    8'b00100_000, // 1  stray grant ignored        R10
    8'b10000_100, // 2  request raised             R2
    8'b10000_100, // 3  still waiting
    8'b10100_010, // 4  granted                    R3
    8'b10000_010, // 5  back-to-back reuse         R8
    8'b00000_000, // 6  release when done          R5
    8'b01000_100, // 7  lock raises request        R2
    8'b01100_011, // 8  granted under lock         R9
    8'b11000_011, // 9  operand one
    8'b01010_011, // 10 strobe gap, other asks     R4 R7
    8'b11010_011, // 11 operand two
    8'b01010_011, // 12 gap again                  R7
    8'b00010_000, // 13 lock over, released        R7
    8'b10001_100, // 14 ROR request
    8'b10101_010, // 15 granted
    8'b00001_010, // 16 idle hold                  R6
    8'b00001_010, // 17 idle hold                  R6
    8'b10001_010, // 18 reuse, no request          R8
    8'b00011_000, // 19 other asks, release        R6
    8'b01001_100, // 20 lock request in ROR
    8'b01111_011, // 21 granted, other waiting
    8'b01011_011, // 22 deferred                   R7
    8'b00011_000, // 23 no extension past lock     R11
    8'b01001_100, // 24
    8'b01101_011, // 25
    8'b00001_010, // 26 idle hold, flag low        R11 R9
    8'b00011_000  // 27 released                   R6
  };
  localparam int VEC_TAG [NVEC] = '{1,10,2,2,3,8,5,2,9,4,7,4,7,7,2,3,6,6,8,6,2,9,7,11,2,9,11,6};

  task automatic check3(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {brOut, busyOut, lockActive};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {br,busy,lock} got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [4:0] v);
    {cpuReq, cpuLock, bgIn, otherReq, rorMode} = v;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(5'b0);
    repeat (3) @(posedge clk);
    #2 check3("R1 reset", 3'b000);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk) drive(VEC[i][7:3]);
      @(posedge clk) #2;
      check3($sformatf("R%0d vec%0d", VEC_TAG[i], i), VEC[i][2:0]);
    end

    // R9: lockActive follows cpuLock between edges while owned (ROR idle hold)
    @(negedge clk) drive(5'b10001);
    @(posedge clk) #2 check3("R2 directed", 3'b100);
    @(negedge clk) drive(5'b10101);
    @(posedge clk) #2 check3("R3 directed", 3'b010);
    @(negedge clk) drive(5'b00001);
    #1 cpuLock = 1'b1;
    #1 check3("R9 flag rises", 3'b011);
    cpuLock = 1'b0;
    #1 check3("R9 flag falls", 3'b010);

    // R1: reset while owning the bus
    @(negedge clk) rstN = 1'b0;
    @(posedge clk) #2 check3("R1 reset when owned", 3'b000);
    @(negedge clk) begin rstN = 1'b1; drive(5'b00000); end
    @(posedge clk) #2 check3("R1 idle after reset", 3'b000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule